// File: doc/BRIEF.md
# Three-Wire Serial Configuration Port

This block receives configuration frames over three slow control lines (a shift clock, a data line and a latch line) and turns them into the settings that steer a stereo attenuator and channel mixer. Each line is brought into the system clock domain through a synchronizer. Every rising edge of the shift clock moves one data bit into a frame register. A rising edge of the latch line then commits the frame to the configuration registers, and all outputs change together in one cycle.

A frame is 17 bits long and is sent least significant bit first. The last bit sent selects the frame kind. An attenuation frame carries both 8-bit channel gain codes. A flag frame carries a 4-bit routing code, the de-emphasis enable and the shared-gain flag. Only the flag frame can change the flag fields, and only the attenuation frame can change the gain codes. The port cannot be read back. A latch that arrives before a full frame has been shifted is discarded, so a truncated transfer cannot corrupt the settings.

Top module: `ctl3w_port`

## Requirements
- R1: Data is sampled on each rising edge of the shift clock. The bit sent first lands in frame bit 0. The 17th bit (frame bit 16) selects the frame kind: 0 for an attenuation frame, 1 for a flag frame.
- R2: In an attenuation frame, frame bits 7:0 become the left gain code and frame bits 15:8 become the right gain code. Each code is sent least significant bit first.
- R3: In a flag frame, frame bits 3:0 become the routing code (bit 0 sent first), bit 4 becomes the de-emphasis enable (1 = on) and bit 5 becomes the shared-gain flag (1 = shared). Bits 15:6 are ignored.
- R4: A flag frame leaves both gain codes unchanged. An attenuation frame leaves the routing code and both flags unchanged.
- R5: A frame is committed on a rising edge of the latch line. Shifting bits without a latch changes no output, and all outputs change in the same cycle.
- R6: A latch rising edge that comes after fewer than 17 shifted bits since the previous latch edge (or since reset) changes no output. Every latch edge restarts the bit count.
- R7: When more than 17 bits are shifted before a latch, the last 17 bits form the frame.
- R8: A synchronous active-high reset sets both gain codes to 8'hFF, the routing code to 4'b1001 (stereo), and clears de-emphasis and the shared-gain flag.
- R9: The outputs show a committed frame at the third system clock edge after the latch line rises, counting the edge that first samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Asynchronous serial shift clock |
| sdat_in | input | 1 | Asynchronous serial data |
| slatch_in | input | 1 | Asynchronous frame latch |
| att_left | output | 8 | Left channel gain code |
| att_right | output | 8 | Right channel gain code |
| route_code | output | 4 | Output routing code |
| deemph_on | output | 1 | De-emphasis enable |
| att_common | output | 1 | Left gain code applies to both channels |

## Verification
Properties checked on every cycle:
- The outputs hold still in any cycle without a commit.
- An attenuation commit loads exactly frame bits 15:0 into the gain codes and leaves the flags untouched.
- A flag commit loads bits 5:0 into the routing and flag fields and leaves the gain codes untouched.
- The defaults appear after reset.

Only the bench scenarios can show the serial side working end to end:
- The least-significant-bit-first bit order through the synchronizers.
- A truncated frame or an empty latch being discarded.
- The last 17 bits of an over-long frame being used.
- The exact three-edge commit latency.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;

    localparam int ATT_W   = 8;
    localparam int ROUTE_W = 4;
    localparam int DATA_W  = 2 * ATT_W;
    localparam int FRAME_W = DATA_W + 1;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam int DEM_BIT = ROUTE_W;
    localparam int COM_BIT = ROUTE_W + 1;

    typedef struct packed {
        logic [ATT_W-1:0]   att_l;
        logic [ATT_W-1:0]   att_r;
        logic [ROUTE_W-1:0] route;
        logic               deemph;
        logic               common;
    } cfg_t;

    localparam logic [ATT_W-1:0]   ATT_RST   = '1;
    localparam logic [ROUTE_W-1:0] ROUTE_RST = 4'b1001;

    localparam cfg_t CFG_RST = '{
        att_l:  ATT_RST,
        att_r:  ATT_RST,
        route:  ROUTE_RST,
        deemph: 1'b0,
        common: 1'b0
    };

    typedef enum logic {
        FRAME_ATT  = 1'b0,
        FRAME_FLAG = 1'b1
    } frame_kind_e;

    function automatic cfg_t merge_frame(input cfg_t cur,
                                         input frame_kind_e kind,
                                         input logic [DATA_W-1:0] pay);
        cfg_t nxt;
        nxt = cur;
        if (kind == FRAME_ATT) begin
            nxt.att_l = pay[ATT_W-1:0];
            nxt.att_r = pay[DATA_W-1:ATT_W];
        end else begin
            nxt.route  = pay[ROUTE_W-1:0];
            nxt.deemph = pay[DEM_BIT];
            nxt.common = pay[COM_BIT];
        end
        return nxt;
    endfunction

endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);

    for (genvar i = 0; i < N; i++) begin : g_line
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk) begin
            if (rst) chain_q <= '0;
            else     chain_q <= {chain_q[STAGES-2:0], async_in[i]};
        end
        assign sync_out[i] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/ctl3w_shift.sv
module ctl3w_shift
    import ctl3w_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sclk_lvl,
    input  logic               sdat_lvl,
    input  logic               slat_lvl,
    output logic [FRAME_W-1:0] frame_q,
    output logic               commit
);

    logic             sclk_prev_q, slat_prev_q;
    logic [CNT_W-1:0] cnt_q;
    logic             sclk_rise, slat_rise, full;

    assign sclk_rise = sclk_lvl & ~sclk_prev_q;
    assign slat_rise = slat_lvl & ~slat_prev_q;
    assign full      = (cnt_q == CNT_W'(FRAME_W));
    assign commit    = slat_rise & full;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev_q <= 1'b0;
            slat_prev_q <= 1'b0;
            cnt_q       <= '0;
            frame_q     <= '0;
        end else begin
            sclk_prev_q <= sclk_lvl;
            slat_prev_q <= slat_lvl;
            if (sclk_rise)
                frame_q <= {sdat_lvl, frame_q[FRAME_W-1:1]};
            if (slat_rise)
                cnt_q <= '0;
            else if (sclk_rise && !full)
                cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/ctl3w_regs.sv
module ctl3w_regs
    import ctl3w_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic              kind_bit,
    input  logic [DATA_W-1:0] payload,
    output cfg_t              cfg_q
);

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= CFG_RST;
        else if (commit)
            cfg_q <= merge_frame(cfg_q, frame_kind_e'(kind_bit), payload);
    end

endmodule

// File: rtl/ctl3w_port.sv
module ctl3w_port
    import ctl3w_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sclk_in,
    input  logic               sdat_in,
    input  logic               slatch_in,
    output logic [ATT_W-1:0]   att_left,
    output logic [ATT_W-1:0]   att_right,
    output logic [ROUTE_W-1:0] route_code,
    output logic               deemph_on,
    output logic               att_common
);

    logic [2:0]         lvl;
    logic [FRAME_W-1:0] frame_q;
    logic               commit;
    cfg_t               cfg;

    ctl3w_sync #(.N(3), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({slatch_in, sdat_in, sclk_in}),
        .sync_out (lvl)
    );

    ctl3w_shift u_shift (
        .clk      (clk),
        .rst      (rst),
        .sclk_lvl (lvl[0]),
        .sdat_lvl (lvl[1]),
        .slat_lvl (lvl[2]),
        .frame_q  (frame_q),
        .commit   (commit)
    );

    ctl3w_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .commit   (commit),
        .kind_bit (frame_q[FRAME_W-1]),
        .payload  (frame_q[DATA_W-1:0]),
        .cfg_q    (cfg)
    );

    assign att_left   = cfg.att_l;
    assign att_right  = cfg.att_r;
    assign route_code = cfg.route;
    assign deemph_on  = cfg.deemph;
    assign att_common = cfg.common;

endmodule

// File: rtl/ctl3w_checker.sv
module ctl3w_checker
    import ctl3w_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               commit,
    input logic [FRAME_W-1:0] frame,
    input logic [ATT_W-1:0]   att_left,
    input logic [ATT_W-1:0]   att_right,
    input logic [ROUTE_W-1:0] route_code,
    input logic               deemph_on,
    input logic               att_common
);

    logic rst_d = 1'b0;
    always_ff @(posedge clk) rst_d <= rst;

    // R8: defaults right after a reset cycle
    always @(negedge clk) begin
        if (rst_d && !rst)
            a_r8_defaults: assert (att_left == ATT_RST && att_right == ATT_RST &&
                                   route_code == ROUTE_RST && !deemph_on && !att_common);
    end

    a_r5_hold_without_commit: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable({att_left, att_right, route_code, deemph_on, att_common}));

    a_r4_flag_keeps_att: assert property (@(posedge clk) disable iff (rst)
        (commit && frame[FRAME_W-1]) |=> $stable({att_left, att_right}));

    a_r4_att_keeps_flags: assert property (@(posedge clk) disable iff (rst)
        (commit && !frame[FRAME_W-1]) |=> $stable({route_code, deemph_on, att_common}));

    a_r2_att_load: assert property (@(posedge clk) disable iff (rst)
        (commit && !frame[FRAME_W-1]) |=>
            (att_left == $past(frame[ATT_W-1:0]) && att_right == $past(frame[DATA_W-1:ATT_W])));

    a_r3_flag_load: assert property (@(posedge clk) disable iff (rst)
        (commit && frame[FRAME_W-1]) |=>
            (route_code == $past(frame[ROUTE_W-1:0]) && deemph_on == $past(frame[DEM_BIT]) &&
             att_common == $past(frame[COM_BIT])));

endmodule

bind ctl3w_port ctl3w_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .commit     (commit),
    .frame      (frame_q),
    .att_left   (att_left),
    .att_right  (att_right),
    .route_code (route_code),
    .deemph_on  (deemph_on),
    .att_common (att_common)
);

// File: tb/tb_ctl3w_port.sv
module tb_ctl3w_port;
    import ctl3w_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0, sdat = 1'b0, slat = 1'b0;
    logic [ATT_W-1:0]   att_left, att_right;
    logic [ROUTE_W-1:0] route_code;
    logic               deemph_on, att_common;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    ctl3w_port dut (
        .clk(clk), .rst(rst), .sclk_in(sclk), .sdat_in(sdat), .slatch_in(slat),
        .att_left(att_left), .att_right(att_right), .route_code(route_code),
        .deemph_on(deemph_on), .att_common(att_common)
    );

    // {frame[16:0], exp left, exp right, exp route, exp deemph, exp common}
    localparam int NV = 6;
    localparam logic [38:0] VEC [NV] = '{
        {17'h03CA5, 8'hA5, 8'h3C, 4'h9, 1'b0, 1'b0},
        {17'h1FFF6, 8'hA5, 8'h3C, 4'h6, 1'b1, 1'b1},
        {17'h0FF00, 8'h00, 8'hFF, 4'h6, 1'b1, 1'b1},
        {17'h10000, 8'h00, 8'hFF, 4'h0, 1'b0, 1'b0},
        {17'h00180, 8'h80, 8'h01, 4'h0, 1'b0, 1'b0},
        {17'h10019, 8'h80, 8'h01, 4'h9, 1'b1, 1'b0}
    };

    task automatic check(input string req, input logic [21:0] exp);
        logic [21:0] act;
        act = {att_left, att_right, route_code, deemph_on, att_common};
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_bits(input logic [31:0] bits, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) sdat = bits[i];
            repeat (2) @(negedge clk);
            sclk = 1'b1;
            repeat (3) @(negedge clk);
            sclk = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    // raise latch, return at the negedge after the third posedge (R9 sample point)
    task automatic raise_latch();
        @(negedge clk) slat = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drop_latch();
        slat = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R8 reset defaults", {8'hFF, 8'hFF, 4'b1001, 1'b0, 1'b0});

        // R1 R2 R3 R4 R5 R9: table of frames
        for (int v = 0; v < NV; v++) begin
            send_bits({15'd0, VEC[v][38:22]}, FRAME_W);
            raise_latch();
            check($sformatf("R1/R2/R3/R4/R9 vector %0d", v), VEC[v][21:0]);
            drop_latch();
        end

        // R6: short frame then latch is ignored
        send_bits(32'h0, 10);
        raise_latch();
        check("R6 short frame ignored", {8'h80, 8'h01, 4'h9, 1'b1, 1'b0});
        drop_latch();

        // R6: latch with no bits is ignored
        raise_latch();
        check("R6 empty latch ignored", {8'h80, 8'h01, 4'h9, 1'b1, 1'b0});
        drop_latch();

        // R5: shifting without latch changes nothing
        send_bits({15'd0, 17'h01122}, FRAME_W);
        repeat (6) @(negedge clk);
        check("R5 no change before latch", {8'h80, 8'h01, 4'h9, 1'b1, 1'b0});
        raise_latch();
        check("R5 commit on latch", {8'h22, 8'h11, 4'h9, 1'b1, 1'b0});
        drop_latch();

        // R7: 19 bits, last 17 used
        send_bits({13'd0, 17'h07733, 2'b11}, FRAME_W + 2);
        raise_latch();
        check("R7 over-long frame", {8'h33, 8'h77, 4'h9, 1'b1, 1'b0});
        drop_latch();

        // R8: reset after configuration restores defaults
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R8 reset restores defaults", {8'hFF, 8'hFF, 4'b1001, 1'b0, 1'b0});

        // R6: bit count restarts on reset; full flag frame after reset
        send_bits({15'd0, 17'h1002A}, FRAME_W);
        raise_latch();
        check("R3 flag frame after reset", {8'hFF, 8'hFF, 4'hA, 1'b0, 1'b1});
        drop_latch();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule